// File: doc/BRIEF.md
# Per-Line Privilege Access Filter

This block sits between a simple register bus and the configuration storage of a bank of general-purpose I/O lines. The lines are grouped 32 to a word. Every line carries one access-level bit, which is either privileged (0) or user (1). Bus accesses arrive through one of two mirrored address windows. The user window covers the range below 0x1000, and the privileged window covers 0x1000 and above.

Each window reaches only the lines of its own level. A write through the wrong window leaves that line's bit untouched, and a read through it returns 0 for that bit. The access-level bits can only be changed through write-one-to-set registers in the privileged window, and a status register reports them. An access to the privileged window without the privileged qualifier changes nothing, reads 0 and raises a one-cycle error pulse.

Reads are combinational in the cycle the access is presented. Writes take effect at the next rising clock edge.

Top module: `prio_line_filter`

## Requirements
- R1: After reset every line is privileged (all status bits 0), all line configuration bits are 0 and `acc_err` is low.
- R2: A privileged write of value V to the set-user register of group g (address 0x10B0 + 0x40*g) makes line n of group g user-access for every bit n that is 1 in V. Lines whose bit in V is 0 keep their level.
- R3: A privileged write of value V to the set-privileged register of group g (address 0x1034 + 0x40*g) makes line n privileged for every bit n that is 1 in V. Lines whose bit in V is 0 keep their level.
- R4: A privileged read of the status register of group g (address 0x1038 + 0x40*g) returns the level bits of that group, with 1 for a user line and 0 for a privileged line.
- R5: A write of V to the user-window configuration word of group g (address 0x40*g) updates only the bits of user lines. Privileged lines keep their stored value. A read at that address returns the stored bits of user lines and 0 for privileged lines.
- R6: A privileged write of V to the privileged-window configuration word of group g (address 0x1000 + 0x40*g) updates only the bits of privileged lines. A read at that address returns the stored bits of privileged lines and 0 for user lines.
- R7: Any access to an address at or above 0x1000 without `bus_priv` changes no state and reads 0. In the cycle after it, `acc_err` is high for exactly one cycle, unless the next access is also such an access.
- R8: Addresses that match none of the registers above read 0, and writes to them change no state. The set-user and set-privileged registers read 0, and the level registers are not reachable from the user window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access carries the privileged qualifier |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not a read hit) |
| acc_err | output | 1 | One-cycle pulse after a non-privileged access to the privileged window |

## Verification
The hardest situation to reach is a group whose user and privileged lines are mixed, with distinct stored values on both sides. Each window's masking is only visible when a write through one window meets stored bits that the other window owns. The stimulus first scatters the level bits with random set-user and set-privileged writes. It then issues random configuration writes through both windows, interleaved with reads through both windows and with privilege-less probes of the privileged window. Every read is compared with a bench model built from the requirements.

// File: rtl/prio_line_filter.sv
module prio_line_filter #(
  parameter int NGROUPS = 2,
  parameter int ADDR_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              acc_err
);
  localparam int LINES = 32;
  localparam logic [5:0] OFF_CFG  = 6'h00;
  localparam logic [5:0] OFF_SU   = 6'h30;
  localparam logic [5:0] OFF_SP   = 6'h34;
  localparam logic [5:0] OFF_STAT = 6'h38;

  logic [LINES-1:0] lvl [NGROUPS];
  logic [LINES-1:0] cfg [NGROUPS];
  logic [NGROUPS-1:0] cfg_hit, su_hit, sp_hit, st_hit;

  wire       priv_win = (ADDR_W > 12) ? bus_addr[12] : 1'b0;
  wire [5:0] blk      = bus_addr[11:6];
  wire [5:0] roff     = bus_addr[5:0];
  wire       denied   = bus_valid & priv_win & ~bus_priv;
  wire       granted  = bus_valid & ~denied;

  always_comb begin
    for (int g = 0; g < NGROUPS; g++) begin
      cfg_hit[g] = granted && blk == 6'(g) && roff == OFF_CFG;
      sp_hit[g]  = granted && priv_win && blk == 6'(g) && roff == OFF_SP;
      st_hit[g]  = granted && priv_win && blk == 6'(g) && roff == OFF_STAT;
      su_hit[g]  = granted && priv_win && blk == 6'(g + 2) && roff == OFF_SU;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGROUPS; g++) begin
        lvl[g] <= '0;
        cfg[g] <= '0;
      end
      acc_err <= 1'b0;
    end else begin
      acc_err <= denied;
      for (int g = 0; g < NGROUPS; g++) begin
        if (bus_write && su_hit[g])
          lvl[g] <= lvl[g] | bus_wdata;
        else if (bus_write && sp_hit[g])
          lvl[g] <= lvl[g] & ~bus_wdata;
        if (bus_write && cfg_hit[g])
          cfg[g] <= (cfg[g] & ~(priv_win ? ~lvl[g] : lvl[g]))
                  | (bus_wdata & (priv_win ? ~lvl[g] : lvl[g]));
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_write)
      for (int g = 0; g < NGROUPS; g++) begin
        if (cfg_hit[g]) bus_rdata |= cfg[g] & (priv_win ? ~lvl[g] : lvl[g]);
        if (st_hit[g])  bus_rdata |= lvl[g];
      end
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_chk
    assert_userwin_keeps_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && !priv_win && cfg_hit[g])
        |=> (((cfg[g] ^ $past(cfg[g])) & ~lvl[g]) == '0));
    assert_privwin_keeps_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && priv_win && cfg_hit[g])
        |=> (((cfg[g] ^ $past(cfg[g])) & lvl[g]) == '0));
    assert_user_set_only_by_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_write && su_hit[g]) |=> ((lvl[g] & ~$past(lvl[g])) == '0));
    assert_priv_set_only_by_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_write && sp_hit[g]) |=> ((~lvl[g] & $past(lvl[g])) == '0));
    assert_denied_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      denied |=> ($stable(lvl[g]) && $stable(cfg[g])));
  end
  assert_denied_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    denied |-> (bus_rdata == '0));
  assert_err_follows_denied_R7: assert property (@(posedge clk) disable iff (!rst_n)
    denied |=> acc_err);
endmodule

// File: tb/prio_line_filter_bench.sv
module prio_line_filter_bench;
  localparam int NG = 2;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_priv = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic acc_err;
  int checks = 0, failures = 0;
  logic [31:0] m_lvl [NG];
  logic [31:0] m_cfg [NG];
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_line_filter #(.NGROUPS(NG), .ADDR_W(13)) u_prio_line_filter (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .acc_err(acc_err));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [12:0] a, bit p);
    int blk = int'(a[11:6]);
    int ro = int'(a[5:0]);
    if (a[12] && !p) return 0;
    if (ro == 0 && blk < NG) return a[12] ? (m_cfg[blk] & ~m_lvl[blk]) : (m_cfg[blk] & m_lvl[blk]);
    if (a[12] && ro == 'h38 && blk < NG) return m_lvl[blk];
    return 0;
  endfunction

  function automatic void model_wr(logic [12:0] a, logic [31:0] d, bit p);
    int blk = int'(a[11:6]);
    int ro = int'(a[5:0]);
    logic [31:0] reach;
    if (a[12] && !p) return;
    if (ro == 0 && blk < NG) begin
      reach = a[12] ? ~m_lvl[blk] : m_lvl[blk];
      m_cfg[blk] = (m_cfg[blk] & ~reach) | (d & reach);
    end else if (a[12] && ro == 'h34 && blk < NG) m_lvl[blk] &= ~d;
    else if (a[12] && ro == 'h30 && blk >= 2 && blk - 2 < NG) m_lvl[blk-2] |= d;
  endfunction

  task automatic access(string req, bit wr, logic [12:0] a, logic [31:0] d, bit p);
    bit exp_err = a[12] && !p;
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_priv = p;
    #1;
    if (!wr) check(req, bus_rdata, model_rd(a, p));
    else model_wr(a, d, p);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check({req, "/R7 err"}, 32'(acc_err), 32'(exp_err));
  endtask

  initial begin
    #20000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int g = 0; g < NG; g++) begin m_lvl[g] = 0; m_cfg[g] = 0; end
    repeat (3) @(negedge clk);
    check("R1 err", 32'(acc_err), 0);
    rst_n = 1;
    access("R1 status0", 0, 13'h1038, 0, 1);
    access("R1 cfg0", 0, 13'h1000, 0, 1);
    access("R1 status1", 0, 13'h1078, 0, 1);
    // R2 directed: set line 4 of group 0 user, then extra bits
    access("R2", 1, 13'h10B0, 32'h10, 1);
    access("R2 status", 0, 13'h1038, 0, 1);
    check("R2 direct", m_lvl[0], 32'h10);
    access("R2", 1, 13'h10B0, 32'h0000_0F00, 1);
    access("R2 accum", 0, 13'h1038, 0, 1);
    // R3 directed: group 1 line 3 set user then priv
    access("R2 g1", 1, 13'h10F0, 32'hFF, 1);
    access("R3", 1, 13'h1074, 32'h8, 1);
    access("R3 status g1", 0, 13'h1078, 0, 1);
    access("R4 status g0 unchanged", 0, 13'h1038, 0, 1);
    // R5 / R6 mixed writes
    access("R5 wr", 1, 13'h0000, 32'hFFFF_FFFF, 0);
    access("R5 rd", 0, 13'h0000, 0, 0);
    access("R6 rd after user wr", 0, 13'h1000, 0, 1);
    access("R6 wr", 1, 13'h1000, 32'hA5A5_A5A5, 1);
    access("R6 rd", 0, 13'h1000, 0, 1);
    access("R5 rd after priv wr", 0, 13'h0000, 0, 0);
    // R7 denied access
    access("R7 denied wr", 1, 13'h10B0, 32'hFFFF_FFFF, 0);
    access("R7 denied rd", 0, 13'h1038, 0, 0);
    access("R7 state kept", 0, 13'h1038, 0, 1);
    access("R7 err clears", 0, 13'h0000, 0, 0);
    // R8 unmapped / write-only / user-window mirror of level regs
    access("R8 su reads 0", 0, 13'h10B0, 0, 1);
    access("R8 sp reads 0", 0, 13'h1034, 0, 1);
    access("R8 user mirror status", 0, 13'h0038, 0, 0);
    access("R8 user mirror su wr", 1, 13'h00B0, 32'hFFFF_FFFF, 0);
    access("R8 level kept", 0, 13'h1038, 0, 1);
    access("R8 unmapped wr", 1, 13'h1204, 32'hFFFF_FFFF, 1);
    access("R8 unmapped rd", 0, 13'h1204, 0, 1);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int k = int'($urandom_range(0, 7));
      int g = int'($urandom_range(0, NG - 1));
      bit p = ($urandom_range(0, 5) != 0);
      bit wr = $urandom_range(0, 1) == 1;
      logic [31:0] d = $urandom;
      logic [12:0] a;
      case (k)
        0: a = 13'(g * 'h40);
        1: a = 13'('h1000 + g * 'h40);
        2: a = 13'('h10B0 + g * 'h40);
        3: a = 13'('h1034 + g * 'h40);
        4: a = 13'('h1038 + g * 'h40);
        5: a = 13'('h1038 + g * 'h40);
        6: a = 13'(g * 'h40);
        default: a = {13'($urandom) & 13'h1FFC};
      endcase
      if (k >= 4 && k <= 6) wr = 0;
      if (a[12]) access(wr ? "R6/R2/R3 rnd wr" : "R4/R6 rnd rd", wr, a, d, p);
      else access(wr ? "R5 rnd wr" : "R5/R8 rnd rd", wr, a, d, p);
    end
    for (int g = 0; g < NG; g++) begin
      access("R4 final status", 0, 13'('h1038 + g * 'h40), 0, 1);
      access("R5 final", 0, 13'(g * 'h40), 0, 0);
      access("R6 final", 0, 13'('h1000 + g * 'h40), 0, 1);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule